// File: doc/BRIEF.md
# Secure Memory Aperture Guard

This block guards one protected window of a 34-bit physical address space. A small register port sets where the window starts, how long it is, which clients may read or write inside it, and two protection controls. The first control freezes every setting for good. The second admits configuration writes only from secure masters. A second port takes memory requests, each carrying an address, a client number and a direction. One cycle later it answers with a hit flag and an allow flag.

The window length is written as a count of 128 KB blocks plus a count of 4 KB residual blocks, so any 4 KB multiple can be described. Inside the window, a request passes only when its client holds the grant for that direction. Outside the window, every request passes. A refused request raises a sticky violation flag and records the offending address. Software clears the flag by writing one to a status bit, and this clear still works after the settings are frozen.

Top module: `carveout_guard`

## Requirements
- R1: After reset every register slot reads zero, the lock and the secure-only control are off, and `rsp_valid`, `rsp_hit`, `rsp_allow` and `viol_flag` are low.
- R2: The window length is 131072 times size bits 26:0 plus 4096 times size bits 31:27 (size register at byte offset 0x219C). A request hits exactly when base <= address < base + length.
- R3: Base low (offset 0x2194) keeps write bits 31:12 as address bits 31:12 and reads back with bits 11:0 zero. Base high (offset 0x2198) keeps its bits 1:0 as address bits 33:32 and reads back with all other bits zero.
- R4: Config (offset 0x2190) bit 1 is a lock. From the cycle after it is written as one, every configuration write is ignored until reset.
- R5: While config bit 0 is set, a configuration write takes effect only when `cfg_secure` is high.
- R6: Six grant words sit at offsets 0x21A0 + 4*k. Client c uses word c/14. Its read grant is bit c%14 of that word and its write grant is bit c%14 + 18. The CPU is client 21, so it uses bits 7 and 25 of the word at 0x21A4. Clients 84 and above hold no grant.
- R7: A request that misses the window is always allowed. A request that hits it is allowed only when its grant bit is one.
- R8: A window of zero length never hits, whatever the base.
- R9: A refused request sets the violation flag, which is status bit 0 at offset 0x21D0. It records the address: bits 31:0 go to offset 0x21D4 and bits 33:32 to status bits 5:4. The first recorded address is kept while the flag is set. Writing one to status bit 0 clears the flag. This clear ignores both the lock and the secure-only control. A refusal in the same cycle as a clear wins and records its own address.
- R10: `cfg_rdata` carries the slot value in the cycle after `cfg_ren` and is zero in every other cycle. Offsets outside 0x2190..0x21D4, and offsets that are not word aligned, read zero. The six force-internal words at 0x21B8 + 4*k store and return all 32 bits.
- R11: `rsp_valid` follows `req_valid` by one cycle. `rsp_hit` and `rsp_allow` are low whenever `rsp_valid` is low. A configuration write in the same cycle as a request does not affect that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 16 | Register byte offset |
| cfg_wen | input | 1 | Register write strobe |
| cfg_ren | input | 1 | Register read strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_secure | input | 1 | Secure attribute of the register access |
| cfg_rdata | output | 32 | Register read data, one cycle after `cfg_ren` |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 34 | Request address |
| req_client | input | 7 | Requesting client number |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Request fell inside the window |
| rsp_allow | output | 1 | Request may proceed |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
The assertions assume that `rst_n` is held low from time zero and that the clock toggles freely. They also assume that the register port and the request port are driven with known values whenever a strobe is high. The stability properties for the lock and the secure-only control rely on the only state-changing path into the settings being a write through the register port. The bench changes strobes, addresses and data only at the falling clock edge. It raises at most one register strobe per access and lowers it in the next half cycle, so every strobe the properties see belongs to exactly one access.

// File: rtl/carveout_pkg.sv
package carveout_pkg;
  localparam int ADDR_W      = 34;
  localparam int REG_W       = 32;
  localparam int BLK_SHIFT   = 17;   // 128 KB block
  localparam int RES_SHIFT   = 12;   // 4 KB residual
  localparam int RES_LSB     = 27;   // residual count field start
  localparam int ACC_REGS    = 6;
  localparam int CL_PER_REG  = 14;
  localparam int WR_BIT_OFS  = 18;
  localparam int NUM_CLIENTS = ACC_REGS * CL_PER_REG;
  localparam int CLIENT_W    = 7;
  localparam int LEN_W       = ADDR_W + 11;
  localparam int END_W       = LEN_W + 1;
  localparam int GRANT_W     = ACC_REGS * REG_W;
  localparam int GIDX_W      = $clog2(GRANT_W);

  // Window length in bytes from the packed size word.
  function automatic logic [LEN_W-1:0] span_bytes(input logic [REG_W-1:0] sz);
    logic [LEN_W-1:0] blk, res;
    blk = LEN_W'(sz[RES_LSB-1:0]) << BLK_SHIFT;
    res = LEN_W'(sz[REG_W-1:RES_LSB]) << RES_SHIFT;
    return blk + res;
  endfunction

  // Position of a client's grant bit in the flattened grant words.
  function automatic logic [GIDX_W-1:0] grant_slot(input logic [CLIENT_W-1:0] c,
                                                   input logic wr);
    int unsigned word, lane;
    word = int'(c) / CL_PER_REG;
    lane = int'(c) % CL_PER_REG + (wr ? WR_BIT_OFS : 0);
    return GIDX_W'(word * REG_W + lane);
  endfunction
endpackage

// File: rtl/carveout_regs.sv
module carveout_regs
  import carveout_pkg::*;
#(
  parameter logic [15:0] BLK_OFS = 16'h2190
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cfg_addr,
  input  logic                 cfg_wen,
  input  logic                 cfg_ren,
  input  logic [REG_W-1:0]     cfg_wdata,
  input  logic                 cfg_secure,
  output logic [REG_W-1:0]     cfg_rdata,
  input  logic                 deny_ev,
  input  logic [ADDR_W-1:0]    deny_addr,
  output logic [ADDR_W-1:0]    ap_base,
  output logic [REG_W-1:0]     ap_size,
  output logic [GRANT_W-1:0]   grants,
  output logic                 viol_flag
);
  localparam int NSLOT    = 18;
  localparam int SLOT_W   = 5;
  localparam int SL_CFG   = 0;
  localparam int SL_BLO   = 1;
  localparam int SL_BHI   = 2;
  localparam int SL_SIZE  = 3;
  localparam int SL_ACC0  = 4;
  localparam int SL_FINT0 = SL_ACC0 + ACC_REGS;
  localparam int SL_STAT  = SL_FINT0 + ACC_REGS;
  localparam int SL_VADDR = SL_STAT + 1;

  logic [1:0]                    cfg_q;
  logic [19:0]                   blo_q;
  logic [1:0]                    bhi_q;
  logic [REG_W-1:0]              size_q;
  logic [ACC_REGS-1:0][REG_W-1:0] acc_q;
  logic [ACC_REGS-1:0][REG_W-1:0] fint_q;
  logic                          viol_q;
  logic [ADDR_W-1:0]             vaddr_q;

  // Decode of the byte offset into a slot number.
  logic [15:0]       rel;
  logic              slot_ok;
  logic [SLOT_W-1:0] slot;
  assign rel     = cfg_addr - BLK_OFS;
  assign slot_ok = (cfg_addr >= BLK_OFS) && (rel[1:0] == 2'b00) &&
                   (rel[15:2] < 14'(NSLOT));
  assign slot    = rel[SLOT_W+1:2];

  // Named protection events.
  logic lock_q, seconly_q, wr_open, clr_req;
  assign lock_q    = cfg_q[1];
  assign seconly_q = cfg_q[0];
  assign wr_open   = cfg_wen && slot_ok && !lock_q && (!seconly_q || cfg_secure);
  assign clr_req   = cfg_wen && slot_ok && (slot == SLOT_W'(SL_STAT)) && cfg_wdata[0];

  logic [ACC_REGS-1:0] acc_we, fint_we;
  for (genvar k = 0; k < ACC_REGS; k++) begin : g_we
    assign acc_we[k]  = wr_open && (slot == SLOT_W'(SL_ACC0 + k));
    assign fint_we[k] = wr_open && (slot == SLOT_W'(SL_FINT0 + k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      blo_q  <= '0;
      bhi_q  <= '0;
      size_q <= '0;
      acc_q  <= '0;
      fint_q <= '0;
    end else begin
      if (wr_open && slot == SLOT_W'(SL_CFG))  cfg_q  <= cfg_wdata[1:0];
      if (wr_open && slot == SLOT_W'(SL_BLO))  blo_q  <= cfg_wdata[31:12];
      if (wr_open && slot == SLOT_W'(SL_BHI))  bhi_q  <= cfg_wdata[1:0];
      if (wr_open && slot == SLOT_W'(SL_SIZE)) size_q <= cfg_wdata;
      for (int k = 0; k < ACC_REGS; k++) begin
        if (acc_we[k])  acc_q[k]  <= cfg_wdata;
        if (fint_we[k]) fint_q[k] <= cfg_wdata;
      end
    end
  end

  // Violation capture: first offender kept, refusal beats a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q  <= 1'b0;
      vaddr_q <= '0;
    end else if (deny_ev && (!viol_q || clr_req)) begin
      viol_q  <= 1'b1;
      vaddr_q <= deny_addr;
    end else if (clr_req) begin
      viol_q  <= 1'b0;
    end
  end

  logic [REG_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (slot)
      SLOT_W'(SL_CFG):   rd_val = {30'b0, cfg_q};
      SLOT_W'(SL_BLO):   rd_val = {blo_q, 12'b0};
      SLOT_W'(SL_BHI):   rd_val = {30'b0, bhi_q};
      SLOT_W'(SL_SIZE):  rd_val = size_q;
      SLOT_W'(SL_STAT):  rd_val = {26'b0, vaddr_q[33:32], 3'b0, viol_q};
      SLOT_W'(SL_VADDR): rd_val = vaddr_q[31:0];
      default: begin
        for (int k = 0; k < ACC_REGS; k++) begin
          if (slot == SLOT_W'(SL_ACC0 + k))  rd_val = acc_q[k];
          if (slot == SLOT_W'(SL_FINT0 + k)) rd_val = fint_q[k];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cfg_rdata <= '0;
    else if (cfg_ren && slot_ok) cfg_rdata <= rd_val;
    else                         cfg_rdata <= '0;
  end

  assign ap_base   = {bhi_q, blo_q, 12'b0};
  assign ap_size   = size_q;
  assign grants    = acc_q;
  assign viol_flag = viol_q;

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cfg_q) && $stable(blo_q) && $stable(bhi_q) &&
               $stable(size_q) && $stable(acc_q) && $stable(fint_q)); // R4

  AST_SECURE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    seconly_q && cfg_wen && !cfg_secure |=> $stable(cfg_q) && $stable(blo_q) &&
               $stable(bhi_q) && $stable(size_q) && $stable(acc_q)); // R5

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q && !clr_req |=> viol_q && $stable(vaddr_q)); // R9

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ren |=> cfg_rdata == '0); // R10
endmodule

// File: rtl/carveout_match.sv
module carveout_match
  import carveout_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [CLIENT_W-1:0]  req_client,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    ap_base,
  input  logic [REG_W-1:0]     ap_size,
  input  logic [GRANT_W-1:0]   grants,
  output logic                 deny_ev,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_allow
);
  logic [LEN_W-1:0]  span;
  logic [END_W-1:0]  ap_end;
  logic              in_win, client_known, granted;
  logic [GIDX_W-1:0] gslot;

  assign span         = span_bytes(ap_size);
  assign ap_end       = END_W'(ap_base) + END_W'(span);
  assign in_win       = (req_addr >= ap_base) && (END_W'(req_addr) < ap_end);
  assign gslot        = grant_slot(req_client, req_write);
  assign client_known = int'(req_client) < NUM_CLIENTS;
  assign granted      = client_known && grants[gslot];
  assign deny_ev      = req_valid && in_win && !granted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && in_win;
      rsp_allow <= req_valid && (!in_win || granted);
    end
  end

  AST_ZERO_SPAN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ap_size == '0 |=> !rsp_hit && rsp_allow); // R8

  AST_BELOW_BASE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr < ap_base |=> !rsp_hit && rsp_allow); // R7

  AST_UNKNOWN_CLIENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && int'(req_client) >= NUM_CLIENTS |=> !(rsp_hit && rsp_allow)); // R6

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11

  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit && !rsp_allow); // R11
endmodule

// File: rtl/carveout_guard.sv
module carveout_guard
  import carveout_pkg::*;
#(
  parameter logic [15:0] BLK_OFS = 16'h2190
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_addr,
  input  logic        cfg_wen,
  input  logic        cfg_ren,
  input  logic [31:0] cfg_wdata,
  input  logic        cfg_secure,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic [33:0] req_addr,
  input  logic [6:0]  req_client,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_allow,
  output logic        viol_flag
);
  logic [ADDR_W-1:0]  ap_base;
  logic [REG_W-1:0]   ap_size;
  logic [GRANT_W-1:0] grants;
  logic               deny_ev;

  carveout_regs #(.BLK_OFS(BLK_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_wen(cfg_wen), .cfg_ren(cfg_ren),
    .cfg_wdata(cfg_wdata), .cfg_secure(cfg_secure), .cfg_rdata(cfg_rdata),
    .deny_ev(deny_ev), .deny_addr(req_addr),
    .ap_base(ap_base), .ap_size(ap_size), .grants(grants),
    .viol_flag(viol_flag)
  );

  carveout_match u_match (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .req_client(req_client), .req_write(req_write),
    .ap_base(ap_base), .ap_size(ap_size), .grants(grants),
    .deny_ev(deny_ev),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_allow(rsp_allow)
  );

  AST_DENY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_allow |-> viol_flag); // R9
endmodule

// File: tb/carveout_guard_bench.sv
`timescale 1ns/1ps
module carveout_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic        cfg_wen = 1'b0, cfg_ren = 1'b0, cfg_secure = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [33:0] req_addr = '0;
  logic [6:0]  req_client = '0;
  logic        rsp_valid, rsp_hit, rsp_allow, viol_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] sh_acc [6];

  always #2.5 clk = ~clk;

  carveout_guard u_carveout_guard (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wen(cfg_wen),
    .cfg_ren(cfg_ren), .cfg_wdata(cfg_wdata), .cfg_secure(cfg_secure),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_client(req_client), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_allow(rsp_allow), .viol_flag(viol_flag)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d, logic sec);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_secure = sec; cfg_wen = 1'b1;
    @(negedge clk);
    cfg_wen = 1'b0; cfg_secure = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_ren = 1'b1;
    @(negedge clk);
    cfg_ren = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic rd_chk(string tag, logic [15:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, 64'(d), 64'(exp));
  endtask

  task automatic req(logic [33:0] a, logic [6:0] c, logic w,
                     output logic h, output logic al);
    @(negedge clk);
    req_addr = a; req_client = c; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    h = rsp_hit; al = rsp_allow;
    check("R11 rsp_valid", 64'(rsp_valid), 64'd1);
  endtask

  // Reference: window test and grant lookup, from the requirement text.
  function automatic logic ref_hit(logic [47:0] base, logic [31:0] sz, logic [47:0] a);
    logic [47:0] len;
    len = 48'(sz & 32'h07FF_FFFF) * 48'd131072 + 48'(sz >> 27) * 48'd4096;
    return (a >= base) && (a < base + len);
  endfunction

  function automatic logic ref_grant(int c, logic w);
    if (c >= 84) return 1'b0;
    return sh_acc[c / 14][(c % 14) + (w ? 18 : 0)];
  endfunction

  task automatic sweep(string tag, logic [33:0] base, logic [31:0] sz,
                       logic [33:0] a, int cmax);
    logic h, al, eh;
    for (int c = 0; c < cmax; c++) begin
      for (int w = 0; w < 2; w++) begin
        req(a, 7'(c), w[0], h, al);
        eh = ref_hit(48'(base), sz, 48'(a));
        check({tag, " R2 hit"}, 64'(h), 64'(eh));
        check({tag, " R7 allow"}, 64'(al), 64'(!eh || ref_grant(c, w[0])));
      end
    end
  endtask

  localparam logic [33:0] B = 34'h1_3000_0000;
  localparam logic [31:0] SZ = (32'd3 << 27) | 32'd2;   // 0x43000 bytes

  initial begin
    logic h, al;
    logic [33:0] pts [8];
    for (int k = 0; k < 6; k++) sh_acc[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid", 64'(rsp_valid), 0);
    check("R1 viol", 64'(viol_flag), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 18; s++) rd_chk("R1 reset read", 16'(16'h2190 + 4 * s), 0);

    // R3: base assembly
    wr(16'h2194, 32'h3000_0ABC, 1'b0);
    wr(16'h2198, 32'hFFFF_FFFD, 1'b0);
    rd_chk("R3 base low", 16'h2194, 32'h3000_0000);
    rd_chk("R3 base high", 16'h2198, 32'h1);
    wr(16'h219C, SZ, 1'b0);
    rd_chk("R2 size", 16'h219C, SZ);
    sh_acc[0] = 32'h0004_0001; sh_acc[1] = 32'h0200_0080;
    sh_acc[2] = 32'h0000_3FFF; sh_acc[3] = 32'hFFFC_0000;
    sh_acc[4] = 32'h5555_5555; sh_acc[5] = 32'h8000_2000;
    for (int k = 0; k < 6; k++) wr(16'(16'h21A0 + 4 * k), sh_acc[k], 1'b0);
    for (int k = 0; k < 6; k++) rd_chk("R6 grant word", 16'(16'h21A0 + 4 * k), sh_acc[k]);
    // R10: force-internal words hold full data
    for (int k = 0; k < 6; k++) wr(16'(16'h21B8 + 4 * k), 32'hA5A5_0000 + 32'(k), 1'b0);
    for (int k = 0; k < 6; k++) rd_chk("R10 force word", 16'(16'h21B8 + 4 * k), 32'hA5A5_0000 + 32'(k));

    // R6: CPU grant at client 21
    req(B + 34'h100, 7'd21, 1'b0, h, al); check("R6 cpu read", 64'(al), 1);
    req(B + 34'h100, 7'd21, 1'b1, h, al); check("R6 cpu write", 64'(al), 1);

    // R2/R7: sweep of edge addresses against all clients and directions
    pts[0] = B - 34'h1000; pts[1] = B - 34'h1; pts[2] = B;
    pts[3] = B + 34'h43000 - 34'h1; pts[4] = B + 34'h43000;
    pts[5] = B + 34'h2_0000; pts[6] = 34'h0; pts[7] = 34'h3_FFFF_FFFF;
    for (int p = 0; p < 8; p++) sweep("R2/R7", B, SZ, pts[p], 90);

    // R9: violation capture
    wr(16'h21D0, 32'h1, 1'b0);
    rd_chk("R9 cleared", 16'h21D0, 32'h10);
    req(B + 34'h10, 7'd22, 1'b0, h, al);
    check("R9 deny", 64'(al), 0);
    check("R9 flag", 64'(viol_flag), 1);
    req(B + 34'h20, 7'd22, 1'b0, h, al);
    rd_chk("R9 status", 16'h21D0, 32'h11);
    rd_chk("R9 first address kept", 16'h21D4, 32'h3000_0010);
    wr(16'h21D0, 32'h1, 1'b0);
    check("R9 clear", 64'(viol_flag), 0);

    // R8: zero length
    wr(16'h219C, 32'h0, 1'b0);
    req(B, 7'd22, 1'b0, h, al);
    check("R8 zero hit", 64'(h), 0); check("R8 zero allow", 64'(al), 1);
    // R2: residual only, then block only
    wr(16'h219C, 32'h0800_0000, 1'b0);
    req(B + 34'hFFF, 7'd22, 1'b0, h, al);  check("R2 res in", 64'(h), 1);
    req(B + 34'h1000, 7'd22, 1'b0, h, al); check("R2 res out", 64'(h), 0);
    wr(16'h219C, 32'h1, 1'b0);
    req(B + 34'h1FFFF, 7'd22, 1'b0, h, al); check("R2 blk in", 64'(h), 1);
    req(B + 34'h20000, 7'd22, 1'b0, h, al); check("R2 blk out", 64'(h), 0);
    wr(16'h21D0, 32'h1, 1'b0);

    // R10: unmapped, misaligned, idle
    rd_chk("R10 below", 16'h218C, 0);
    rd_chk("R10 above", 16'h21D8, 0);
    rd_chk("R10 misaligned", 16'h2192, 0);
    @(negedge clk); check("R10 idle rdata", 64'(cfg_rdata), 0);

    // R5: secure-only
    wr(16'h2190, 32'h1, 1'b1);
    wr(16'h219C, 32'h5, 1'b0);
    rd_chk("R5 nonsecure ignored", 16'h219C, 32'h1);
    wr(16'h219C, 32'h2, 1'b1);
    rd_chk("R5 secure taken", 16'h219C, 32'h2);

    // R4: lock
    wr(16'h2190, 32'h3, 1'b1);
    rd_chk("R4 cfg", 16'h2190, 32'h3);
    wr(16'h219C, 32'h7, 1'b1);
    rd_chk("R4 size frozen", 16'h219C, 32'h2);
    wr(16'h21A4, 32'h0, 1'b1);
    req(B, 7'd21, 1'b1, h, al); check("R4 grant frozen", 64'(al), 1);
    wr(16'h2190, 32'h0, 1'b1);
    rd_chk("R4 lock sticks", 16'h2190, 32'h3);
    req(B, 7'd22, 1'b0, h, al);
    check("R9 deny locked", 64'(viol_flag), 1);
    wr(16'h21D0, 32'h1, 1'b0);
    rd_chk("R9 clear after lock", 16'h21D0, 32'h10);

    // R1: reset releases lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 lock released", 16'h2190, 0);
    rd_chk("R1 size cleared", 16'h219C, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule